// File: doc/BRIEF.md
# Graded-Flag Word FIFO

This block is a first-in first-out buffer for 9-bit words. A producer pushes words in parallel. A downstream serializer takes the oldest word from a read port that shows it without delay, and consumes it with a read strobe. A write address, a read address and an occupancy count are kept internally. From the count, a registered region state machine drives four active-low status outputs: a Full flag, an Empty flag, a Half-Full flag, and one shared flag that warns of both a nearly empty and a nearly full buffer.

The whole design runs on one clock. Write, read and rewind are single-cycle enable pulses sampled on the rising edge. The rewind command moves only the read address back to location zero, so the stored words can be sent again. The write address stays where it is. The depth is a parameter and must be a power of two, at least 8.

Two state machines are used. The control unit decodes each cycle into one operation: OP_HOLD (nothing), OP_PUSH (write only), OP_POP (read only), OP_SWAP (a write and a read together) or OP_REWIND. The flag unit holds a region state. RG_EMPTY means 0 words. RG_SPARSE covers 1 to depth/8−1 words. RG_MID covers depth/8 to depth/2. RG_UPPER covers depth/2+1 to 7·depth/8. RG_CROWDED covers 7·depth/8+1 to depth−1. RG_FULL means depth words. On every clock the region moves to whichever region the current count falls in. Reset forces it to RG_EMPTY. Each region decodes to a fixed set of flag levels.

Top module: `graded_flag_fifo`

## Requirements
- R1: A synchronous reset (rst_n low on a clock edge) clears both addresses and the count. After reset, full_n=1, half_n=1, almost_n=0 and empty_n=0.
- R2: An accepted write stores wr_data at the write address, which then advances modulo depth. rd_data always shows the word at the read address, and an accepted read advances that address. Words therefore leave in the order they were written.
- R3: A write while the count equals depth is ignored, even if a read is requested in the same cycle. Nothing is stored and the write address does not move.
- R4: A read while the count is zero is ignored, even if a write is requested in the same cycle. The read address does not move.
- R5: almost_n is 0 when the count is below depth/8 or above 7·depth/8. Otherwise it is 1.
- R6: half_n is 0 when the count is above depth/2. Otherwise it is 1.
- R7: full_n is 0 only when the count equals depth. empty_n is 0 only when the count is zero.
- R8: When a write and a read are both accepted in one cycle, both take effect and the count is unchanged.
- R9: The flags are registered. A change of count at one clock edge shows on the flags at the next edge.
- R10: A rewind pulse with both wr_strobe and rd_strobe low sets the read address to zero and leaves the write address alone. The new count is the write address, except that a write address of zero with a nonzero count gives depth. A rewind pulse that comes with either strobe high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_strobe | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to write |
| rd_strobe | input | 1 | Read request (consume the head word) |
| rd_data | output | 9 | Word at the read address |
| rewind | input | 1 | Move the read address back to location zero |
| full_n | output | 1 | Low when the count equals depth |
| empty_n | output | 1 | Low when the count is zero |
| half_n | output | 1 | Low when the count is above depth/2 |
| almost_n | output | 1 | Low when the count is below depth/8 or above 7·depth/8 |

## Verification
The bench builds the block with a depth of 16. With that depth the region boundaries fall at 1, 2, 8, 9, 14, 15 and 16 words, so every region and every flag edge is reached within a few dozen cycles. A full fill brings the write address back to zero, which exercises the wrapped-rewind case of R10. The small depth also lets the bench collide writes with a full buffer and reads with an empty one many times over.

// File: rtl/gff_pkg.sv
package gff_pkg;

    // Occupancy regions; each one decodes to a fixed set of flag levels.
    typedef enum logic [2:0] {
        RG_EMPTY,
        RG_SPARSE,
        RG_MID,
        RG_UPPER,
        RG_CROWDED,
        RG_FULL
    } fill_region_e;

    // Operation decoded for the current cycle.
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_REWIND
    } fifo_op_e;

endpackage

// File: rtl/gff_store.sv
module gff_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 9,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // The head word is visible without a read latency.
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/gff_ctrl.sv
module gff_ctrl
    import gff_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              rewind_req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  occ
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] wr_ptr_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0]  occ_q;
    logic [CNT_W-1:0]  rewind_occ;
    logic              push;
    logic              pop;
    fifo_op_e          op;

    // Decode the single operation of this cycle.
    always_comb begin
        push = wr_req && (occ_q < CAP);
        pop  = rd_req && (occ_q != '0);
        if (rewind_req && !wr_req && !rd_req) begin
            op = OP_REWIND;
        end else if (push && pop) begin
            op = OP_SWAP;
        end else if (push) begin
            op = OP_PUSH;
        end else if (pop) begin
            op = OP_POP;
        end else begin
            op = OP_HOLD;
        end
    end

    // Words from location zero up to the write address; a zero address with
    // a nonzero count means the write side has gone round the whole ring.
    always_comb begin
        if (wr_ptr_q == '0 && occ_q != '0) begin
            rewind_occ = CAP;
        end else begin
            rewind_occ = {1'b0, wr_ptr_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr_q <= wr_ptr_q + 1'b1;
                    occ_q    <= occ_q + 1'b1;
                end
                OP_POP: begin
                    rd_ptr_q <= rd_ptr_q + 1'b1;
                    occ_q    <= occ_q - 1'b1;
                end
                OP_SWAP: begin
                    wr_ptr_q <= wr_ptr_q + 1'b1;
                    rd_ptr_q <= rd_ptr_q + 1'b1;
                end
                OP_REWIND: begin
                    rd_ptr_q <= '0;
                    occ_q    <= rewind_occ;
                end
                OP_HOLD: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
    assign wr_addr = wr_ptr_q;
    assign rd_addr = rd_ptr_q;
    assign occ     = occ_q;

endmodule

// File: rtl/gff_flags.sv
module gff_flags
    import gff_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    output logic             full_n,
    output logic             empty_n,
    output logic             half_n,
    output logic             almost_n
);

    localparam logic [CNT_W-1:0] CAP       = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LOW_EDGE  = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] MID_EDGE  = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] HIGH_EDGE = CNT_W'(DEPTH - DEPTH / 8);

    fill_region_e region_q;
    fill_region_e region_d;

    always_comb begin
        if (occ == '0) begin
            region_d = RG_EMPTY;
        end else if (occ < LOW_EDGE) begin
            region_d = RG_SPARSE;
        end else if (occ <= MID_EDGE) begin
            region_d = RG_MID;
        end else if (occ <= HIGH_EDGE) begin
            region_d = RG_UPPER;
        end else if (occ < CAP) begin
            region_d = RG_CROWDED;
        end else begin
            region_d = RG_FULL;
        end
    end

    // State register: one cycle behind the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= RG_EMPTY;
        end else begin
            region_q <= region_d;
        end
    end

    // Output decode of the region state.
    always_comb begin
        full_n   = 1'b1;
        empty_n  = 1'b1;
        half_n   = 1'b1;
        almost_n = 1'b1;
        unique case (region_q)
            RG_EMPTY: begin
                empty_n  = 1'b0;
                almost_n = 1'b0;
            end
            RG_SPARSE: begin
                almost_n = 1'b0;
            end
            RG_MID: begin
            end
            RG_UPPER: begin
                half_n = 1'b0;
            end
            RG_CROWDED: begin
                half_n   = 1'b0;
                almost_n = 1'b0;
            end
            RG_FULL: begin
                full_n   = 1'b0;
                half_n   = 1'b0;
                almost_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/graded_flag_fifo.sv
module graded_flag_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 9,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rewind,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n,
    output logic              almost_n
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  occ_q;

    gff_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_strobe),
        .rd_req     (rd_strobe),
        .rewind_req (rewind),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .occ        (occ_q)
    );

    gff_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    gff_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ      (occ_q),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .half_n   (half_n),
        .almost_n (almost_n)
    );

endmodule

// File: rtl/graded_flag_fifo_chk.sv
module graded_flag_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_strobe,
    input logic              rd_strobe,
    input logic              rewind,
    input logic              full_n,
    input logic              empty_n,
    input logic              half_n,
    input logic              almost_n,
    input logic [CNT_W-1:0]  occ,
    input logic [ADDR_W-1:0] rd_addr
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [1:0] live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 2'd0;
        end else if (live != 2'd2) begin
            live <= live + 2'd1;
        end
    end

    // R1
    reset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (full_n && half_n && !almost_n && !empty_n));

    // R3
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CAP && wr_strobe && !rd_strobe) |=> (occ == CAP));

    // R4
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && rd_strobe && !wr_strobe) |=> (occ == '0 && $stable(rd_addr)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CAP);

    // R7
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd2) |-> ((!full_n) == ($past(occ) == CAP)));

    // R9
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd2) |-> ((!empty_n) == ($past(occ) == '0)));

    // R8
    swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && rd_strobe && occ != '0 && occ != CAP) |=> $stable(occ));

    // R10
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && !wr_strobe && !rd_strobe) |=> (rd_addr == '0));

endmodule

bind graded_flag_fifo graded_flag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .rewind    (rewind),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .half_n    (half_n),
    .almost_n  (almost_n),
    .occ       (occ_q),
    .rd_addr   (rd_addr)
);

// File: tb/graded_flag_fifo_bench.sv
module graded_flag_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_strobe = 1'b0;
    logic       rewind = 1'b0;
    logic [8:0] rd_data;
    logic       full_n, empty_n, half_n, almost_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [8:0] m_mem [DEPTH];
    int m_wa = 0;
    int m_ra = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    graded_flag_fifo #(.DEPTH(DEPTH)) u_graded_flag_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rewind    (rewind),
        .full_n    (full_n),
        .empty_n   (empty_n),
        .half_n    (half_n),
        .almost_n  (almost_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_wa = 0; m_ra = 0; m_cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock with the given strobes; model follows the requirements.
    task automatic step(input logic w, input logic [8:0] d, input logic r, input logic rw);
        bit push, pop;
        wr_strobe = w; wr_data = d; rd_strobe = r; rewind = rw;
        @(posedge clk);
        if (rw && !w && !r) begin
            m_ra  = 0;
            m_cnt = (m_wa == 0 && m_cnt != 0) ? DEPTH : m_wa;
        end else begin
            push = w && (m_cnt < DEPTH);
            pop  = r && (m_cnt != 0);
            if (push) begin
                m_mem[m_wa] = d;
                m_wa = (m_wa + 1) % DEPTH;
            end
            if (pop) m_ra = (m_ra + 1) % DEPTH;
            m_cnt = m_cnt + int'(push) - int'(pop);
        end
        @(negedge clk);
        wr_strobe = 1'b0; rd_strobe = 1'b0; rewind = 1'b0;
    endtask

    // Idle clock so the registered flags catch up, then compare all four.
    task automatic check_flags(input string tag);
        step(1'b0, '0, 1'b0, 1'b0);
        chk({tag, " R7 full_n"},   int'(full_n),   int'(m_cnt != DEPTH));
        chk({tag, " R7 empty_n"},  int'(empty_n),  int'(m_cnt != 0));
        chk({tag, " R6 half_n"},   int'(half_n),   int'(!(m_cnt > DEPTH / 2)));
        chk({tag, " R5 almost_n"}, int'(almost_n),
            int'(!(m_cnt < DEPTH / 8 || m_cnt > DEPTH - DEPTH / 8)));
    endtask

    task automatic chk_head(input string tag);
        chk(tag, int'(rd_data), int'(m_mem[m_ra]));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 full_n",   int'(full_n),   1);
        chk("R1 half_n",   int'(half_n),   1);
        chk("R1 almost_n", int'(almost_n), 0);
        chk("R1 empty_n",  int'(empty_n),  0);
    endtask

    task automatic t_lag();
        do_reset();
        step(1'b1, 9'h055, 1'b0, 1'b0);
        chk("R9 empty_n one cycle late", int'(empty_n), 0);
        step(1'b0, '0, 1'b0, 1'b0);
        chk("R9 empty_n after lag", int'(empty_n), 1);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R9 empty_n still high", int'(empty_n), 1);
        step(1'b0, '0, 1'b0, 1'b0);
        chk("R9 empty_n falls", int'(empty_n), 0);
    endtask

    task automatic t_empty_read();
        do_reset();
        step(1'b0, '0, 1'b1, 1'b0);
        check_flags("R4 read on empty");
        step(1'b1, 9'h1A5, 1'b0, 1'b0);
        chk("R4 head after ignored read", int'(rd_data), 'h1A5);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 9'h033, 1'b1, 1'b0);
        check_flags("R4 read with write on empty");
        chk("R4 head after collided read", int'(rd_data), 'h033);
    endtask

    task automatic t_fill_drain();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 9'(i * 37 + 5), 1'b0, 1'b0);
            check_flags("R2 fill");
        end
        step(1'b1, 9'h1FF, 1'b0, 1'b0);
        check_flags("R3 write on full");
        step(1'b1, 9'h1FE, 1'b1, 1'b0);
        check_flags("R3 write with read on full");
        for (int i = 0; i < DEPTH - 1; i++) begin
            chk_head("R2 drain order");
            step(1'b0, '0, 1'b1, 1'b0);
            check_flags("R2 drain");
        end
        chk("R3 no extra word stored", int'(empty_n), 0);
    endtask

    task automatic t_swap();
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 9'(100 + i), 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            chk_head("R8 head before swap");
            step(1'b1, 9'(200 + i), 1'b1, 1'b0);
            check_flags("R8 swap count");
        end
        for (int i = 0; i < 5; i++) begin
            chk_head("R8 drain after swaps");
            step(1'b0, '0, 1'b1, 1'b0);
        end
        check_flags("R8 end empty");
    endtask

    task automatic t_rewind();
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 9'(300 + i), 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b1, 1'b1);
        chk_head("R10 rewind with read ignored");
        check_flags("R10 rewind with read ignored");
        step(1'b0, '0, 1'b0, 1'b1);
        check_flags("R10 rewind count");
        chk("R10 head is location zero", int'(rd_data), 300);
        step(1'b1, 9'h0AA, 1'b0, 1'b0);
        for (int i = 0; i < 11; i++) begin
            chk_head("R10 replay order");
            step(1'b0, '0, 1'b1, 1'b0);
        end
        check_flags("R10 replay drained");
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 9'(400 + i), 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        check_flags("R10 wrapped rewind");
        chk("R10 wrapped head", int'(rd_data), 400);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_lag();
        t_empty_read();
        t_fill_drain();
        t_swap();
        t_rewind();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule